// File: doc/BRIEF.md
# Voltage-Gated Control Register Window

This block sits on a synchronous CPU byte bus and watches a four-byte address window. Each read or write that lands in the window goes to one of three places:

- a small internal register set (one control byte and two block-enable bytes);
- a reserved area that always reads all ones and drops writes;
- the external bus, through a pass-through request.

Which place is chosen depends on the 2-bit operating mode and on whether programming voltage is present.

The voltage-present input is asynchronous. It is brought into the clock domain through a two-stage synchronizer before it affects any decision. Read data is registered, so a read strobe returns its data on the following clock.

Bit 7 of the control byte reports the voltage. It reads 1 whenever the register is reachable, so it cannot tell software whether voltage is present. Software must instead compare the whole control byte against 0xFF: a reserved-area read always returns exactly 0xFF, while the live register reads 0x80 through 0xFF only by writing its low bits.

Top module: `vgate_window`

## Requirements
- R1: In mode 1 (mode_sel = 2'd1), window accesses go to the reserved area while synchronized voltage is present, and to the external bus while it is absent.
- R2: In mode 2 (mode_sel = 2'd2), window accesses reach the internal registers while voltage is present, and go to the external bus while it is absent.
- R3: In mode 3 (mode_sel = 2'd3), window accesses reach the internal registers while voltage is present, and go to the reserved area while it is absent. ext_req never rises in this mode.
- R4: A reserved-area read returns 0xFF, and a reserved-area write changes no register.
- R5: The control register sits at window offset 0 (address 0xFF80) and reads 0x80 after reset. Its bit 7 reads 1 whenever the register is reachable, and writes to bit 7 are ignored.
- R6: While synchronized voltage is absent, control bits 6..0 are held at 0. When voltage returns, the register reads 0x80.
- R7: The block-enable registers sit at offsets 2 and 3 (0xFF82, 0xFF83). They reset to 0x00, are fully readable and writable while reachable, and keep their contents while not reachable.
- R8: Offset 1 (0xFF81) behaves as the reserved area whenever the registers are selected. In every other case it follows the same route as the rest of the window.
- R9: A change on vpp_present affects decoding exactly two clock edges after the first edge that samples it.
- R10: An external-bus decision raises ext_req in the same cycle as the strobe, and a read returns ext_rdata as sampled on that edge. Reserved and internal decisions, and addresses outside the window, keep ext_req low.
- R11: bus_rdata updates on the clock edge that samples a read strobe and holds its value in cycles without a read.
- R12: With mode_sel = 2'd0, every window access goes to the external bus, regardless of voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mode_sel | input | 2 | Operating mode, 0 to 3 |
| vpp_present | input | 1 | Asynchronous programming-voltage-present level |
| ext_req | output | 1 | Request to the external bus for the current access |
| ext_rdata | input | 8 | Read data returned by the external bus |

## Verification
A wrong synchronizer depth or a wrong route choice shows up at once as a wrong ext_req level in the strobe cycle, or as a wrong bus_rdata value one clock later. A corrupted register bit stays hidden until the next read of that offset, and a missed clear on voltage loss only appears once voltage returns and the control byte is read. The bench therefore reads every offset after each mode and voltage change, and it toggles the voltage directly beside accesses so that an off-by-one delay is caught within two cycles.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_EXT  = 2'd1,
    RT_RSV  = 2'd2,
    RT_REG  = 2'd3
  } route_t;

  localparam logic [1:0] OFS_CTL  = 2'd0;
  localparam logic [1:0] OFS_HOLE = 2'd1;
  localparam logic [1:0] OFS_BE0  = 2'd2;
  localparam logic [1:0] OFS_BE1  = 2'd3;
endpackage

// File: rtl/vgate_sync.sv
module vgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

  // Count edges since reset, so the delay check only looks at inputs
  // that were sampled after reset was released.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3 && STAGES == 2) |-> (sync_out == $past(async_in, 2))); // R9
endmodule

// File: rtl/vgate_route.sv
module vgate_route
  import vgate_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hFF80
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  input  logic              volt_ok,
  output route_t            route,
  output logic [1:0]        offs
);
  localparam int HI_W = ADDR_W - 2;
  localparam logic [HI_W-1:0] BASE_HI = WIN_BASE[ADDR_W-1:2];

  logic   in_win;
  route_t base_route;

  assign in_win = (addr[ADDR_W-1:2] == BASE_HI);
  assign offs   = addr[1:0];

  always_comb begin
    unique case (mode)
      2'd1:    base_route = volt_ok ? RT_RSV : RT_EXT;
      2'd2:    base_route = volt_ok ? RT_REG : RT_EXT;
      2'd3:    base_route = volt_ok ? RT_REG : RT_RSV;
      default: base_route = RT_EXT;
    endcase

    if (!in_win)
      route = RT_NONE;
    else if (base_route == RT_REG && offs == OFS_HOLE)
      route = RT_RSV;
    else
      route = base_route;
  end
endmodule

// File: rtl/vgate_regs.sv
module vgate_regs
  import vgate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_BE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              volt_ok,
  input  logic              wr_en,
  input  logic [1:0]        offs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int CTL_W = DATA_W - 1;

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] be_q [NUM_BE];

  always_ff @(posedge clk) begin
    if (rst || !volt_ok)
      ctl_q <= '0;
    else if (wr_en && offs == OFS_CTL)
      ctl_q <= wdata[CTL_W-1:0];
  end

  generate
    for (genvar b = 0; b < NUM_BE; b++) begin : g_be
      always_ff @(posedge clk) begin
        if (rst)
          be_q[b] <= '0;
        else if (wr_en && offs == OFS_BE0 + 2'(b))
          be_q[b] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    unique case (offs)
      OFS_CTL: rdata = {volt_ok, ctl_q};
      OFS_BE0: rdata = be_q[0];
      OFS_BE1: rdata = be_q[1];
      default: rdata = '1;
    endcase
  end

  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !volt_ok |=> (ctl_q == '0)); // R6
endmodule

// File: rtl/vgate_window.sv
module vgate_window
  import vgate_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] WIN_BASE    = 16'hFF80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        mode_sel,
  input  logic              vpp_present,
  output logic              ext_req,
  input  logic [DATA_W-1:0] ext_rdata
);
  logic              volt_ok;
  route_t            route;
  logic [1:0]        offs;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] mux_rdata;

  vgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(vpp_present), .sync_out(volt_ok)
  );

  vgate_route #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_route (
    .addr(bus_addr), .mode(mode_sel), .volt_ok(volt_ok),
    .route(route), .offs(offs)
  );

  vgate_regs #(.DATA_W(DATA_W), .NUM_BE(2)) u_regs (
    .clk(clk), .rst(rst), .volt_ok(volt_ok),
    .wr_en(bus_wr && route == RT_REG), .offs(offs),
    .wdata(bus_wdata), .rdata(reg_rdata)
  );

  assign ext_req = (bus_rd || bus_wr) && (route == RT_EXT);

  always_comb begin
    unique case (route)
      RT_EXT:  mux_rdata = ext_rdata;
      RT_REG:  mux_rdata = reg_rdata;
      default: mux_rdata = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd && route != RT_NONE)
      bus_rdata <= mux_rdata;
  end

  AST_M3_NO_EXT: assert property (@(posedge clk) disable iff (rst)
    !(mode_sel == 2'd3 && ext_req)); // R3

  AST_RSV_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && route == RT_RSV) |=> (bus_rdata == '1)); // R4

  AST_EXT_RDATA: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ext_req) |=> (bus_rdata == $past(ext_rdata))); // R10

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (route == RT_NONE) |-> !ext_req); // R10
endmodule

// File: tb/vgate_window_bench.sv
module vgate_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic [1:0]  mode_sel = 2'd3;
  logic        vpp_present = 1'b0;
  logic        ext_req;
  logic [7:0]  ext_rdata = 8'h00;

  int vectors = 0, fails = 0;
  int cyc_cnt = 0;

  // reference model state
  int s1 = 0, s2 = 0;
  int m_ctl = 0;
  int m_be[2] = '{0, 0};
  int exp_rd = 0;

  always #5 clk = ~clk;

  vgate_window u_vgate_window (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_sel(mode_sel),
    .vpp_present(vpp_present), .ext_req(ext_req), .ext_rdata(ext_rdata)
  );

  // 0 none, 1 ext, 2 reserved, 3 registers
  function automatic int where_to(input int m, input int v, input int a);
    int r;
    if (a < 16'hFF80 || a > 16'hFF83) return 0;
    if (m == 1)      r = v ? 2 : 1;
    else if (m == 2) r = v ? 3 : 1;
    else if (m == 3) r = v ? 3 : 2;
    else             r = 1;
    if (r == 3 && a == 16'hFF81) r = 2;
    return r;
  endfunction

  function automatic string req_tag(input int m, input int r);
    if (r == 0) return "R10";
    if (m == 0) return "R12";
    if (m == 1) return "R1";
    if (m == 2) return "R2";
    return "R3";
  endfunction

  // model: advances on each edge using the state before the edge
  always @(posedge clk) begin
    int r;
    cyc_cnt++;
    if (rst) begin
      s1 = 0; s2 = 0; m_ctl = 0; m_be[0] = 0; m_be[1] = 0; exp_rd = 0;
    end else begin
      r = where_to(mode_sel, s2, bus_addr);
      if (bus_rd && r != 0) begin
        if (r == 1)      exp_rd = ext_rdata;
        else if (r == 2) exp_rd = 8'hFF;
        else case (bus_addr)
          16'hFF80: exp_rd = 8'h80 | m_ctl;
          16'hFF82: exp_rd = m_be[0];
          default:  exp_rd = m_be[1];
        endcase
      end
      if (bus_wr && r == 3) begin
        if (bus_addr == 16'hFF80) m_ctl = bus_wdata & 8'h7F;
        else if (bus_addr == 16'hFF82) m_be[0] = bus_wdata;
        else if (bus_addr == 16'hFF83) m_be[1] = bus_wdata;
      end
      if (s2 == 0) m_ctl = 0;
      s2 = s1;
      s1 = vpp_present;
    end
  end

  // compare away from the edge, after inputs settle
  always @(negedge clk) begin
    int r;
    bit xr;
    #2;
    r  = where_to(mode_sel, s2, bus_addr);
    xr = (bus_rd || bus_wr) && r == 1 && !rst;
    vectors++;
    if (ext_req !== xr) begin
      fails++;
      $display("FAIL %s/R9 ext_req addr=%h mode=%0d act=%b exp=%b",
               req_tag(mode_sel, r), bus_addr, mode_sel, ext_req, xr);
    end
    vectors++;
    if (bus_rdata !== exp_rd[7:0]) begin
      fails++;
      $display("FAIL R11/R4/R5/R6/R7/R8 rdata act=%h exp=%h", bus_rdata, exp_rd[7:0]);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; ext_rdata = 8'(cyc_cnt * 7 + 3);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1; bus_wr = 0; ext_rdata = 8'(cyc_cnt * 13 + 5);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 0; bus_wr = 1; bus_wdata = d;
  endtask

  task automatic sweep(input logic [7:0] seed);
    for (int k = 0; k < 4; k++) rd(16'hFF80 + 16'(k));
    for (int k = 0; k < 4; k++) wr(16'hFF80 + 16'(k), seed ^ 8'(k * 8'h35));
    for (int k = 0; k < 4; k++) rd(16'hFF80 + 16'(k));
    idle(1);
  endtask

  initial begin
    idle(3);                            // reset state: rdata 0, no ext_req
    @(negedge clk); rst = 0;
    idle(1);
    // R5/R7 reset values in mode 3 with voltage
    vpp_present = 1; idle(3);
    rd(16'hFF80); rd(16'hFF82); rd(16'hFF83); idle(1);
    // R5 bit7 read-only, R8 hole
    wr(16'hFF80, 8'h00); rd(16'hFF80); wr(16'hFF80, 8'hFF); rd(16'hFF80);
    wr(16'hFF81, 8'h12); rd(16'hFF81); idle(1);
    // mode/voltage matrix: R1 R2 R3 R12
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 2; v++) begin
        mode_sel = 2'(m); vpp_present = v[0]; idle(3);
        sweep(8'(8'hA5 + m * 16 + v));
      end
    end
    // R6: voltage loss clears control low bits, R7 retention
    mode_sel = 2'd3; vpp_present = 1; idle(3);
    wr(16'hFF80, 8'h5A); wr(16'hFF82, 8'hC3); rd(16'hFF80);
    vpp_present = 0; idle(4); rd(16'hFF80); rd(16'hFF82);
    vpp_present = 1; idle(3); rd(16'hFF80); rd(16'hFF82); rd(16'hFF83);
    // R9: toggle voltage with back-to-back accesses
    mode_sel = 2'd2;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk); vpp_present = ~vpp_present;
      bus_addr = 16'hFF82; bus_rd = 1; bus_wr = 0; ext_rdata = 8'(t * 29);
      rd(16'hFF80); rd(16'hFF83); wr(16'hFF83, 8'(t * 17));
    end
    idle(3);
    // R10: outside the window, no request and rdata held
    rd(16'hFF7F); rd(16'hFF84); wr(16'h1234, 8'h77); rd(16'h0000); idle(2);
    // R11: hold without a read
    rd(16'hFF82); idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule